// File: doc/BRIEF.md
# Hash-Based Receive Queue Dispatcher

This block sits behind a header parser on the receive path of a multi-queue network interface. For every parsed header it gets, it returns the number of the receive queue that should take the packet. Each core on the host drains its own queues, so the block spreads flows over the cores. All packets of one flow reach the same queue and so stay in order. The choice comes from a keyed Toeplitz hash over the flow's five identifying fields. The low bits of that hash are then reduced modulo the number of queues in use.

Software can change two things while traffic flows, with no reset: which of four built-in hash keys is in use, and how many queues are active. The queue count can drop during quiet periods so that cores can be parked. The block also reads a fill level from every queue. When automatic mode is on and any active queue crosses a fill threshold, the block moves on to the next hash key by itself. A programmable holdoff window then blocks further automatic moves, so the block does not thrash between keys.

Top module: `rxq_dispatch`

## Requirements
- R1: The hash input is a 104-bit string, most significant bit first: protocol (8 bits), source IPv4 address (32), destination IPv4 address (32), source port (16), destination port (16). When `hdr_has_ports` is 0, both port fields count as zero, whatever is on the port inputs.
- R2: The hash is a 32-bit Toeplitz hash with a 136-bit key K. Key byte j (j = 0..16, byte 0 most significant) of key number k is (59*j + 113*k + 90) mod 256. For each input bit i (i = 0 is the most significant) that is 1, the result is XORed with the 32 key bits from K bit position 135-i down to 104-i.
- R3: The queue index is (hash bits [6:0]) mod N, where N is the active queue count. Equal tuples under the same settings always get the same index, and that index is below N.
- R4: Each cycle with `hdr_valid` high produces exactly one cycle with `out_valid` high, two clock edges later. `out_valid` is low at all other times.
- R5: A configuration write (`cfg_valid` high) changes the key number, queue count, automatic enable, threshold and holdoff at that clock edge. A header offered in the same cycle still uses the old settings. Headers in later cycles use the new ones.
- R6: A written queue count of 0 is taken as 1, and a count above 128 is taken as 128.
- R7: After reset, `out_valid` is 0, key number 0 is in use, 128 queues are active, automatic mode is off, the threshold is 255 and the holdoff is 0.
- R8: Automatic mode is on, some queue q below N has `q_fill` byte q (bits 8q+7..8q) at or above the threshold, the holdoff counter is 0, and no write is present. When all of this holds at an edge, the key number moves to (k+1) mod 4 and the holdoff counter is loaded with the programmed holdoff.
- R9: A nonzero holdoff counter blocks automatic moves and counts down by one per cycle. With a holdoff of H and a queue that stays near full, automatic moves happen H+1 cycles apart.
- R10: Fill levels of queues at or above N, and all fill levels while automatic mode is off, never change the key number.
- R11: A configuration write at the same edge as an automatic trigger takes priority: the written key number applies and the holdoff counter is not reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | A parsed header is present this cycle |
| hdr_proto | input | 8 | IP protocol number |
| hdr_src_ip | input | 32 | Source IPv4 address |
| hdr_dst_ip | input | 32 | Destination IPv4 address |
| hdr_src_port | input | 16 | Source port |
| hdr_dst_port | input | 16 | Destination port |
| hdr_has_ports | input | 1 | The packet carries port fields |
| q_fill | input | 1024 | Fill level per queue, 8 bits each, queue q at bits 8q+7..8q |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_count | input | 8 | Number of active queues to use |
| cfg_hash_sel | input | 2 | Hash key number to use |
| cfg_auto_en | input | 1 | Enable automatic key moves |
| cfg_full_thr | input | 8 | Fill level at which a queue counts as near full |
| cfg_holdoff | input | 16 | Cycles that block automatic moves after one has happened |
| out_valid | output | 1 | Queue index valid |
| out_queue | output | 7 | Selected receive queue |

## Verification
A wrong key number or queue count inside the block shows up as a wrong `out_queue` two cycles after the first header that uses the bad setting. With random tuples, about 127 of 128 headers expose a wrong key. A holdoff counter that is off by one, or that misses a reload, moves an automatic key change to the wrong edge. Since headers arrive every cycle while a queue is held near full, the index stream shows that shift within a few packets. The bench keeps its own model of the key number, queue count and holdoff counter. It compares every output cycle against that model, so a timing error in the configuration path shows at the exact header where the settings split.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef struct packed {
        logic [7:0]  proto;
        logic [31:0] src_ip;
        logic [31:0] dst_ip;
        logic [15:0] src_port;
        logic [15:0] dst_port;
    } flow_t;

    localparam int TUPLE_W = $bits(flow_t);
    localparam int KEY_W   = TUPLE_W + 32;

    // one bit of hash key number k, bit position p (0 = lsb of KEY_W)
    function automatic logic key_bit(input int k, input int p);
        int         byte_idx;
        int         val;
        logic [7:0] b;
        byte_idx = (KEY_W - 1 - p) / 8;
        val      = byte_idx * 59 + k * 113 + 90;
        b        = val[7:0];
        return b[p[2:0]];
    endfunction

    function automatic flow_t make_tuple(input logic [7:0] proto,
                                         input logic [31:0] sip,
                                         input logic [31:0] dip,
                                         input logic [15:0] sport,
                                         input logic [15:0] dport,
                                         input logic has_ports);
        flow_t f;
        f.proto    = proto;
        f.src_ip   = sip;
        f.dst_ip   = dip;
        f.src_port = has_ports ? sport : 16'h0;
        f.dst_port = has_ports ? dport : 16'h0;
        return f;
    endfunction

endpackage

// File: rtl/rxq_cfg_ctrl.sv
module rxq_cfg_ctrl #(
    parameter int NUM_Q_MAX = 128,
    parameter int NUM_HASH  = 4,
    parameter int FILL_W    = 8,
    parameter int HOLD_W    = 16,
    localparam int CW = $clog2(NUM_Q_MAX + 1),
    localparam int SW = (NUM_HASH > 1) ? $clog2(NUM_HASH) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_valid,
    input  logic [CW-1:0]               cfg_count,
    input  logic [SW-1:0]               cfg_hash_sel,
    input  logic                        cfg_auto_en,
    input  logic [FILL_W-1:0]           cfg_full_thr,
    input  logic [HOLD_W-1:0]           cfg_holdoff,
    input  logic [NUM_Q_MAX*FILL_W-1:0] q_fill,
    output logic [CW-1:0]               act_count,
    output logic [SW-1:0]               act_sel
);

    typedef struct packed {
        logic [CW-1:0]     count;
        logic [SW-1:0]     sel;
        logic              auto_en;
        logic [FILL_W-1:0] thr;
        logic [HOLD_W-1:0] holdoff;
    } cfg_t;

    cfg_t              cur;
    logic [HOLD_W-1:0] hold_cnt;
    logic              near_any;
    logic              auto_fire;
    logic [CW-1:0]     count_clamped;
    logic [SW-1:0]     sel_next;
    logic [SW-1:0]     sel_wr;

    always_comb begin
        near_any = 1'b0;
        for (int q = 0; q < NUM_Q_MAX; q++) begin
            if ((CW'(q) < cur.count) && (q_fill[q*FILL_W +: FILL_W] >= cur.thr))
                near_any = 1'b1;
        end
    end

    assign auto_fire = cur.auto_en && near_any && (hold_cnt == '0);

    always_comb begin
        if (cfg_count == '0)
            count_clamped = CW'(1);
        else if (cfg_count > CW'(NUM_Q_MAX))
            count_clamped = CW'(NUM_Q_MAX);
        else
            count_clamped = cfg_count;
    end

    always_comb begin
        if (cur.sel == SW'(NUM_HASH - 1))
            sel_next = '0;
        else
            sel_next = cur.sel + SW'(1);
        if (cfg_hash_sel > SW'(NUM_HASH - 1))
            sel_wr = '0;
        else
            sel_wr = cfg_hash_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.count   <= CW'(NUM_Q_MAX);
            cur.sel     <= '0;
            cur.auto_en <= 1'b0;
            cur.thr     <= '1;
            cur.holdoff <= '0;
            hold_cnt    <= '0;
        end else if (cfg_valid) begin
            cur.count   <= count_clamped;
            cur.sel     <= sel_wr;
            cur.auto_en <= cfg_auto_en;
            cur.thr     <= cfg_full_thr;
            cur.holdoff <= cfg_holdoff;
            if (hold_cnt != '0)
                hold_cnt <= hold_cnt - HOLD_W'(1);
        end else if (auto_fire) begin
            cur.sel  <= sel_next;
            hold_cnt <= cur.holdoff;
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - HOLD_W'(1);
        end
    end

    assign act_count = cur.count;
    assign act_sel   = cur.sel;

    assert_count_range_R6: assert property (@(posedge clk) disable iff (rst)
        (act_count >= CW'(1)) && (act_count <= CW'(NUM_Q_MAX)));

    assert_auto_switch_R8: assert property (@(posedge clk) disable iff (rst)
        (cur.auto_en && near_any && hold_cnt == '0 && !cfg_valid) |=> (act_sel != $past(act_sel)));

    assert_holdoff_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        (hold_cnt != '0 && !cfg_valid) |=> $stable(act_sel));

    assert_no_spurious_switch_R10: assert property (@(posedge clk) disable iff (rst)
        (!near_any && !cfg_valid) |=> $stable(act_sel));

    assert_write_wins_R11: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |=> (act_sel == $past(sel_wr)));

endmodule

// File: rtl/rxq_hash.sv
module rxq_hash #(
    parameter int NUM_Q_MAX = 128,
    parameter int NUM_HASH  = 4,
    localparam int QW = $clog2(NUM_Q_MAX),
    localparam int SW = (NUM_HASH > 1) ? $clog2(NUM_HASH) : 1
) (
    input  rxq_pkg::flow_t   tuple,
    input  logic [SW-1:0]    sel,
    output logic [QW-1:0]    bucket
);
    import rxq_pkg::*;

    logic [TUPLE_W-1:0] bits;
    assign bits = tuple;

    // only the low QW bits of the 32-bit Toeplitz result are built
    always_comb begin
        bucket = '0;
        for (int r = 0; r < QW; r++) begin
            logic acc;
            acc = 1'b0;
            for (int i = 0; i < TUPLE_W; i++) begin
                acc = acc ^ (bits[TUPLE_W - 1 - i] & key_bit(int'(sel), TUPLE_W - i + r));
            end
            bucket[r] = acc;
        end
    end

endmodule

// File: rtl/rxq_qmap.sv
module rxq_qmap #(
    parameter int NUM_Q_MAX = 128,
    localparam int QW = $clog2(NUM_Q_MAX),
    localparam int CW = $clog2(NUM_Q_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [QW-1:0] in_bucket,
    input  logic [CW-1:0] in_count,
    output logic          out_valid,
    output logic [QW-1:0] out_queue
);

    logic [CW-1:0] bucket_ext;
    assign bucket_ext = CW'(in_bucket);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_queue <= '0;
        end else begin
            out_valid <= in_valid;
            out_queue <= QW'(bucket_ext % in_count);
        end
    end

    assert_index_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (CW'(out_queue) < $past(in_count)));

endmodule

// File: rtl/rxq_dispatch.sv
module rxq_dispatch #(
    parameter int NUM_Q_MAX = 128,
    parameter int NUM_HASH  = 4,
    parameter int FILL_W    = 8,
    parameter int HOLD_W    = 16,
    localparam int QW = $clog2(NUM_Q_MAX),
    localparam int CW = $clog2(NUM_Q_MAX + 1),
    localparam int SW = (NUM_HASH > 1) ? $clog2(NUM_HASH) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        hdr_valid,
    input  logic [7:0]                  hdr_proto,
    input  logic [31:0]                 hdr_src_ip,
    input  logic [31:0]                 hdr_dst_ip,
    input  logic [15:0]                 hdr_src_port,
    input  logic [15:0]                 hdr_dst_port,
    input  logic                        hdr_has_ports,
    input  logic [NUM_Q_MAX*FILL_W-1:0] q_fill,
    input  logic                        cfg_valid,
    input  logic [CW-1:0]               cfg_count,
    input  logic [SW-1:0]               cfg_hash_sel,
    input  logic                        cfg_auto_en,
    input  logic [FILL_W-1:0]           cfg_full_thr,
    input  logic [HOLD_W-1:0]           cfg_holdoff,
    output logic                        out_valid,
    output logic [QW-1:0]               out_queue
);
    import rxq_pkg::*;

    typedef struct packed {
        logic          vld;
        logic [QW-1:0] bucket;
        logic [CW-1:0] count;
    } stage_t;

    flow_t         tuple;
    logic [CW-1:0] act_count;
    logic [SW-1:0] act_sel;
    logic [QW-1:0] bucket;
    stage_t        s1;
    logic [1:0]    since_rst;

    assign tuple = make_tuple(hdr_proto, hdr_src_ip, hdr_dst_ip,
                              hdr_src_port, hdr_dst_port, hdr_has_ports);

    rxq_cfg_ctrl #(
        .NUM_Q_MAX(NUM_Q_MAX), .NUM_HASH(NUM_HASH),
        .FILL_W(FILL_W), .HOLD_W(HOLD_W)
    ) i_cfg (
        .clk(clk), .rst(rst),
        .cfg_valid(cfg_valid), .cfg_count(cfg_count), .cfg_hash_sel(cfg_hash_sel),
        .cfg_auto_en(cfg_auto_en), .cfg_full_thr(cfg_full_thr), .cfg_holdoff(cfg_holdoff),
        .q_fill(q_fill), .act_count(act_count), .act_sel(act_sel)
    );

    rxq_hash #(.NUM_Q_MAX(NUM_Q_MAX), .NUM_HASH(NUM_HASH)) i_hash (
        .tuple(tuple), .sel(act_sel), .bucket(bucket)
    );

    // stage 1: hash result plus a snapshot of the settings it was made with
    always_ff @(posedge clk) begin
        if (rst) begin
            s1.vld    <= 1'b0;
            s1.bucket <= '0;
            s1.count  <= CW'(NUM_Q_MAX);
        end else begin
            s1.vld    <= hdr_valid;
            s1.bucket <= bucket;
            s1.count  <= act_count;
        end
    end

    rxq_qmap #(.NUM_Q_MAX(NUM_Q_MAX)) i_qmap (
        .clk(clk), .rst(rst),
        .in_valid(s1.vld), .in_bucket(s1.bucket), .in_count(s1.count),
        .out_valid(out_valid), .out_queue(out_queue)
    );

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'd2)
            since_rst <= since_rst + 2'd1;
    end

    assert_two_cycle_latency_R4: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2) |-> (out_valid == $past(hdr_valid, 2)));

    assert_reset_quiet_R7: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);

endmodule

// File: tb/test_rxq_dispatch.sv
module test_rxq_dispatch;

    localparam int NQ = 128;
    localparam int FW = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            hdr_valid = 1'b0;
    logic [7:0]      hdr_proto = '0;
    logic [31:0]     hdr_src_ip = '0;
    logic [31:0]     hdr_dst_ip = '0;
    logic [15:0]     hdr_src_port = '0;
    logic [15:0]     hdr_dst_port = '0;
    logic            hdr_has_ports = 1'b0;
    logic [NQ*FW-1:0] q_fill = '0;
    logic            cfg_valid = 1'b0;
    logic [7:0]      cfg_count = '0;
    logic [1:0]      cfg_hash_sel = '0;
    logic            cfg_auto_en = 1'b0;
    logic [7:0]      cfg_full_thr = '0;
    logic [15:0]     cfg_holdoff = '0;
    logic            out_valid;
    logic [6:0]      out_queue;

    always #10 clk = ~clk;

    rxq_dispatch i_rxq_dispatch (
        .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_proto(hdr_proto),
        .hdr_src_ip(hdr_src_ip), .hdr_dst_ip(hdr_dst_ip),
        .hdr_src_port(hdr_src_port), .hdr_dst_port(hdr_dst_port),
        .hdr_has_ports(hdr_has_ports), .q_fill(q_fill),
        .cfg_valid(cfg_valid), .cfg_count(cfg_count), .cfg_hash_sel(cfg_hash_sel),
        .cfg_auto_en(cfg_auto_en), .cfg_full_thr(cfg_full_thr), .cfg_holdoff(cfg_holdoff),
        .out_valid(out_valid), .out_queue(out_queue)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    string tag = "R7";
    bit    done = 1'b0;

    // reference model state, from the requirements
    int       m_sel, m_count, m_thr, m_hold_set, m_hold;
    bit       m_auto;
    bit       e1_v, e2_v;
    int       e1_q, e2_q;

    function automatic logic [7:0] key_byte(int k, int j);
        int v;
        v = (59 * j + 113 * k + 90) % 256;
        return v[7:0];
    endfunction

    function automatic logic [31:0] ref_hash(int k, logic [103:0] t);
        logic [135:0] key;
        logic [31:0]  h;
        for (int j = 0; j < 17; j++) key[135 - 8*j -: 8] = key_byte(k, j);
        h = '0;
        for (int i = 0; i < 104; i++)
            if (t[103 - i]) h = h ^ key[135 - i -: 32];
        return h;
    endfunction

    function automatic int ref_queue(int k, int cnt);
        logic [103:0] t;
        logic [31:0]  h;
        t = {hdr_proto, hdr_src_ip, hdr_dst_ip,
             hdr_has_ports ? hdr_src_port : 16'h0,
             hdr_has_ports ? hdr_dst_port : 16'h0};
        h = ref_hash(k, t);
        return int'(h[6:0]) % cnt;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sel = 0; m_count = 128; m_auto = 0; m_thr = 255;
            m_hold_set = 0; m_hold = 0;
            e1_v = 0; e2_v = 0; e1_q = 0; e2_q = 0;
        end else begin
            bit near;
            e2_v = e1_v; e2_q = e1_q;
            e1_v = hdr_valid;
            if (hdr_valid) e1_q = ref_queue(m_sel, m_count);
            near = 0;
            for (int q = 0; q < NQ; q++)
                if (q < m_count && int'(q_fill[q*FW +: FW]) >= m_thr) near = 1;
            if (cfg_valid) begin
                m_sel = int'(cfg_hash_sel);
                m_count = (cfg_count == 0) ? 1 : (int'(cfg_count) > 128 ? 128 : int'(cfg_count));
                m_auto = cfg_auto_en;
                m_thr = int'(cfg_full_thr);
                m_hold_set = int'(cfg_holdoff);
                if (m_hold != 0) m_hold = m_hold - 1;
            end else if (m_auto && near && m_hold == 0) begin
                m_sel = (m_sel + 1) % 4;
                m_hold = m_hold_set;
            end else if (m_hold != 0) begin
                m_hold = m_hold - 1;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (rst) begin
                if (out_valid !== 1'b0) begin
                    n_errors++;
                    $display("FAIL R7 out_valid in reset: got %b expected 0", out_valid);
                end
            end else begin
                if (out_valid !== e2_v) begin
                    n_errors++;
                    $display("FAIL R4 out_valid: got %b expected %b", out_valid, e2_v);
                end else if (e2_v) begin
                    n_checks++;
                    if (int'(out_queue) !== e2_q) begin
                        n_errors++;
                        $display("FAIL %s out_queue: got %0d expected %0d", tag, out_queue, e2_q);
                    end
                end
            end
        end
    end

    task automatic rand_hdr(int pct);
        hdr_valid     = ($urandom % 100) < pct;
        hdr_proto     = $urandom;
        hdr_src_ip    = $urandom;
        hdr_dst_ip    = $urandom;
        hdr_src_port  = $urandom;
        hdr_dst_port  = $urandom;
        hdr_has_ports = $urandom % 2;
    endtask

    task automatic write_cfg(int cnt, int sel, bit aen, int thr, int hold);
        cfg_valid = 1; cfg_count = 8'(cnt); cfg_hash_sel = 2'(sel);
        cfg_auto_en = aen; cfg_full_thr = 8'(thr); cfg_holdoff = 16'(hold);
    endtask

    task automatic run(int cycles, int pct);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            cfg_valid = 0;
            rand_hdr(pct);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 0;
        tag = "R7";                      // reset settings: key 0, 128 queues
        run(6, 100);

        tag = "R1";                      // same tuple with and without ports
        for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            rand_hdr(100);
            hdr_has_ports = 0;
            @(negedge clk);
            hdr_has_ports = 1; hdr_src_port = 0; hdr_dst_port = 0;
        end

        tag = "R2";
        run(200, 80);

        tag = "R3";                      // a repeated flow keeps its queue
        @(negedge clk); write_cfg(37, 1, 0, 255, 0); rand_hdr(100);
        for (int n = 0; n < 10; n++) begin
            @(negedge clk); cfg_valid = 0;
        end

        tag = "R5";                      // write coincides with a header
        @(negedge clk); rand_hdr(100); write_cfg(10, 2, 0, 255, 0);
        run(20, 100);
        @(negedge clk); rand_hdr(100); write_cfg(100, 3, 0, 255, 0);
        run(20, 100);

        tag = "R6";
        @(negedge clk); write_cfg(0, 0, 0, 255, 0); rand_hdr(100);
        run(20, 100);
        @(negedge clk); write_cfg(200, 1, 0, 255, 0); rand_hdr(100);
        run(40, 100);
        @(negedge clk); write_cfg(128, 2, 0, 255, 0); rand_hdr(100);
        run(20, 100);

        tag = "R10";                     // full queue outside the active set
        @(negedge clk); write_cfg(50, 0, 1, 200, 3); rand_hdr(100);
        q_fill[100*FW +: FW] = 8'd255;
        run(40, 100);
        @(negedge clk); write_cfg(128, 0, 0, 200, 3); rand_hdr(100);
        q_fill[5*FW +: FW] = 8'd255;
        run(40, 100);
        q_fill = '0;

        tag = "R8";
        @(negedge clk); write_cfg(128, 0, 1, 200, 6); rand_hdr(100);
        q_fill[3*FW +: FW] = 8'd250;
        tag = "R9";
        run(60, 100);
        q_fill = '0;
        run(10, 100);

        tag = "R11";                     // write lands on an automatic trigger
        @(negedge clk); write_cfg(128, 0, 1, 200, 0); rand_hdr(100);
        q_fill[0 +: FW] = 8'd255;
        @(negedge clk); write_cfg(128, 2, 1, 200, 4); rand_hdr(100);
        run(30, 100);
        q_fill = '0;

        tag = "R4";                      // random mix of everything
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            cfg_valid = 0;
            rand_hdr(70);
            if ($urandom % 50 == 0)
                write_cfg($urandom % 256, $urandom % 4, $urandom % 2,
                          150 + $urandom % 100, $urandom % 12);
            if ($urandom % 20 == 0)
                q_fill[($urandom % NQ)*FW +: FW] = 8'($urandom);
        end
        cfg_valid = 0; hdr_valid = 0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule